// File: doc/BRIEF.md
# SMBus Block Transfer Byte Buffer

This block holds the payload of one SMBus block transfer. It sits between a byte-wide host register port and the bus engine. The host reaches the storage through a single block-data register. Every access to that register moves on to the next entry, and a read of the control register sets the host position back to entry zero. The byte count of the transfer is kept in the count register. For a write transfer the host loads the count there before pushing the payload. For a read transfer the engine stores the received count there after it has filled the storage.

On the engine side, a transfer begins with a start pulse that gives the direction. The start sets the engine's own position back to zero, so the engine reads (transmit) or fills (receive) entries in order. An end pulse, which may carry an error, moves the sequencer into a check step. The check step reports a protocol error when a received count falls outside 1 to DEPTH. A transfer that ends in error leaves the storage as it was and reports the failure only through a status output. Every part of this, on both sides, works only while the buffer-mode bit of the auxiliary register is set.

The sequencer has four states. ST_IDLE goes to ST_TX on an accepted transmit start and to ST_RX on an accepted receive start. ST_TX and ST_RX both go to ST_CHECK on an end pulse. ST_CHECK always returns to ST_IDLE after one cycle. A start is accepted only in ST_IDLE with buffer mode on.

Top module: `smb_blkbuf`

## Requirements
- R1: The storage has DEPTH (default 32) byte entries, all zero after reset. Bytes written through the block-data register (select 2) read back in the same order.
- R2: A host read of the control register (select 0, which reads as zero) sets the host position to entry 0.
- R3: Each host access to the block-data register, read or write, moves the host position on by exactly one entry. A read returns the entry at the current position.
- R4: The host position saturates at entry DEPTH-1 and does not wrap. Further writes overwrite that last entry, and further reads keep returning it.
- R5: The count register (select 1) reads back what the host wrote. It is also shown on `e_count`. In a receive transfer the engine's count strobe overwrites it.
- R6: Buffer mode is bit 1 of the auxiliary register (select 3). While it is clear, block-data writes store nothing, block-data reads return zero and do not move the position, and engine starts are ignored.
- R7: An accepted start sets the engine position to 0. In a transmit transfer, successive engine reads give entries 0, 1, 2, … in order.
- R8: In a receive transfer, successive engine writes fill entries 0, 1, 2, … in order, and the host can read them after a control read.
- R9: When a receive transfer ends without error and its count is 0 or above DEPTH, `proto_err` is raised. Counts 1 and DEPTH raise nothing. The flags clear on the next accepted start.
- R10: An end with the error input set raises `xfer_err` and not `proto_err`, and it changes no stored byte.
- R11: With HAS_BUF set to 0, the buffer-mode bit cannot be set and reads back as 0.
- R12: `busy` is high in ST_TX, ST_RX and ST_CHECK. The flags show their result in the cycle `busy` falls, two clock edges after the end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 2 | Host register select: 0 control, 1 count, 2 block data, 3 auxiliary |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data for the selected register |
| e_start | input | 1 | Engine transfer start pulse |
| e_dir_rx | input | 1 | Direction with the start: 1 receive, 0 transmit |
| e_rd | input | 1 | Engine takes the next byte (transmit) |
| e_rdata | output | DW | Byte at the engine position |
| e_wr | input | 1 | Engine stores a received byte (receive) |
| e_wdata | input | DW | Received byte |
| e_cnt_vld | input | 1 | Engine stores the received count |
| e_cnt | input | DW | Received count |
| e_end | input | 1 | Transfer end pulse |
| e_err | input | 1 | Transfer ended with a bus error |
| e_count | output | DW | Count register value |
| busy | output | 1 | Sequencer is not in ST_IDLE |
| proto_err | output | 1 | Received count out of range |
| xfer_err | output | 1 | Last transfer ended with an error |
| buf_mode | output | 1 | Buffer-mode bit |

## Verification
Random payloads with random lengths are written by the host and read back by both the host and the engine. This separates correct ordering and index stepping from skipped or repeated entries. An interleaved write/read/write pattern shows that reads also move the position. A 33-byte overrun tells saturation apart from wrap-around. Receive transfers are run with counts 1, DEPTH, 0 and DEPTH+1 to find the exact range limits. An error-terminated receive, and accesses made with buffer mode off, are then read back to show that nothing beyond the written entries was disturbed.

// File: rtl/smb_blkbuf_pkg.sv
package smb_blkbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TX    = 2'd1,
        ST_RX    = 2'd2,
        ST_CHECK = 2'd3
    } seq_state_t;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_BLK  = 2'd2;
    localparam logic [1:0] SEL_AUX  = 2'd3;
    localparam int         AUX_BUF_BIT = 1;
endpackage

// File: rtl/smb_blkbuf_index.sv
module smb_blkbuf_index #(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     adv,
    output logic [$clog2(DEPTH)-1:0] idx
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (adv && (idx != LAST)) begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/smb_blkbuf_store.sv
module smb_blkbuf_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wa_en,
    input  logic [$clog2(DEPTH)-1:0] wa_idx,
    input  logic [DW-1:0]            wa_data,
    input  logic                     wb_en,
    input  logic [$clog2(DEPTH)-1:0] wb_idx,
    input  logic [DW-1:0]            wb_data,
    input  logic [$clog2(DEPTH)-1:0] ra_idx,
    output logic [DW-1:0]            ra_data,
    input  logic [$clog2(DEPTH)-1:0] rb_idx,
    output logic [DW-1:0]            rb_data
);
    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else if (wb_en && (wb_idx == IW'(g))) begin
                ent[g] <= wb_data;
            end else if (wa_en && (wa_idx == IW'(g))) begin
                ent[g] <= wa_data;
            end
        end
    end

    assign ra_data = ent[ra_idx];
    assign rb_data = ent[rb_idx];
endmodule

// File: rtl/smb_blkbuf_seq.sv
module smb_blkbuf_seq
    import smb_blkbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          start,
    input  logic          dir_rx,
    input  logic          fin,
    input  logic          fin_err,
    input  logic [CW-1:0] cnt,
    output seq_state_t    state,
    output logic          accept,
    output logic          busy,
    output logic          proto_err,
    output logic          xfer_err
);
    localparam logic [CW-1:0] MAXC = CW'(DEPTH);

    seq_state_t nxt;
    logic       rx_q;
    logic       err_q;
    logic       cnt_bad;

    assign accept  = (state == ST_IDLE) && start && enable;
    assign busy    = (state != ST_IDLE);
    assign cnt_bad = (cnt == '0) || (cnt > MAXC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = dir_rx ? ST_RX : ST_TX;
            ST_TX:    if (fin) nxt = ST_CHECK;
            ST_RX:    if (fin) nxt = ST_CHECK;
            ST_CHECK: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q      <= 1'b0;
            err_q     <= 1'b0;
            proto_err <= 1'b0;
            xfer_err  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        rx_q      <= dir_rx;
                        err_q     <= 1'b0;
                        proto_err <= 1'b0;
                        xfer_err  <= 1'b0;
                    end
                end
                ST_TX, ST_RX: begin
                    if (fin) err_q <= fin_err;
                end
                ST_CHECK: begin
                    xfer_err  <= err_q;
                    proto_err <= !err_q && rx_q && cnt_bad;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf
    import smb_blkbuf_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int DW      = 8,
    parameter bit HAS_BUF = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    h_sel,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          e_start,
    input  logic          e_dir_rx,
    input  logic          e_rd,
    output logic [DW-1:0] e_rdata,
    input  logic          e_wr,
    input  logic [DW-1:0] e_wdata,
    input  logic          e_cnt_vld,
    input  logic [DW-1:0] e_cnt,
    input  logic          e_end,
    input  logic          e_err,
    output logic [DW-1:0] e_count,
    output logic          busy,
    output logic          proto_err,
    output logic          xfer_err,
    output logic          buf_mode
);
    localparam int IW = $clog2(DEPTH);

    seq_state_t    state;
    logic          accept;
    logic [IW-1:0] host_idx;
    logic [IW-1:0] eng_idx;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] host_byte;
    logic          host_clr;
    logic          host_acc;
    logic          host_wen;
    logic          eng_wen;
    logic          eng_adv;
    logic          in_tx;
    logic          in_rx;

    assign in_tx    = (state == ST_TX);
    assign in_rx    = (state == ST_RX);
    assign host_clr = h_rd && (h_sel == SEL_CTRL);
    assign host_acc = (h_wr || h_rd) && (h_sel == SEL_BLK) && buf_mode;
    assign host_wen = h_wr && (h_sel == SEL_BLK) && buf_mode;
    assign eng_wen  = in_rx && e_wr;
    assign eng_adv  = (in_tx && e_rd) || eng_wen;

    if (HAS_BUF) begin : g_aux
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         buf_mode <= 1'b0;
            else if (h_wr && h_sel == SEL_AUX)  buf_mode <= h_wdata[AUX_BUF_BIT];
        end
    end else begin : g_noaux
        assign buf_mode = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (in_rx && e_cnt_vld)      cnt_q <= e_cnt;
        else if (h_wr && h_sel == SEL_CNT) cnt_q <= h_wdata;
    end

    smb_blkbuf_index #(.DEPTH(DEPTH)) u_host_idx (
        .clk(clk), .rst_n(rst_n), .clr(host_clr), .adv(host_acc), .idx(host_idx)
    );

    smb_blkbuf_index #(.DEPTH(DEPTH)) u_eng_idx (
        .clk(clk), .rst_n(rst_n), .clr(accept), .adv(eng_adv), .idx(eng_idx)
    );

    smb_blkbuf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wa_en(host_wen), .wa_idx(host_idx), .wa_data(h_wdata),
        .wb_en(eng_wen),  .wb_idx(eng_idx),  .wb_data(e_wdata),
        .ra_idx(host_idx), .ra_data(host_byte),
        .rb_idx(eng_idx),  .rb_data(e_rdata)
    );

    smb_blkbuf_seq #(.DEPTH(DEPTH), .CW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(buf_mode), .start(e_start),
        .dir_rx(e_dir_rx), .fin(e_end), .fin_err(e_err), .cnt(cnt_q),
        .state(state), .accept(accept), .busy(busy),
        .proto_err(proto_err), .xfer_err(xfer_err)
    );

    always_comb begin
        unique case (h_sel)
            SEL_CTRL: h_rdata = '0;
            SEL_CNT:  h_rdata = cnt_q;
            SEL_BLK:  h_rdata = buf_mode ? host_byte : '0;
            SEL_AUX:  h_rdata = DW'({buf_mode, 1'b0});
            default:  h_rdata = '0;
        endcase
    end

    assign e_count = cnt_q;
endmodule

// File: rtl/smb_blkbuf_chk.sv
module smb_blkbuf_chk #(
    parameter int DEPTH = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               h_sel,
    input logic                     h_wr,
    input logic                     h_rd,
    input logic                     e_start,
    input logic                     buf_mode,
    input logic                     busy,
    input logic                     proto_err,
    input logic                     xfer_err,
    input logic [$clog2(DEPTH)-1:0] hidx,
    input logic [$clog2(DEPTH)-1:0] eidx
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic ctrl_rd;
    logic blk_acc;
    assign ctrl_rd = h_rd && (h_sel == 2'd0);
    assign blk_acc = (h_rd || h_wr) && (h_sel == 2'd2) && buf_mode;

    AST_HOST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |=> (hidx == '0)); // R2
    AST_HOST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_acc && hidx != LAST) |=> (hidx == IW'($past(hidx) + 1'b1))); // R3
    AST_IDX_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (hidx == LAST && !ctrl_rd) |=> (hidx == LAST)); // R4
    AST_MODE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_mode && !ctrl_rd) |=> $stable(hidx)); // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (e_start && !busy && buf_mode) |=> (busy && eidx == '0)); // R7
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(proto_err && xfer_err)); // R10
endmodule

bind smb_blkbuf smb_blkbuf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_rd(h_rd),
    .e_start(e_start), .buf_mode(buf_mode), .busy(busy),
    .proto_err(proto_err), .xfer_err(xfer_err),
    .hidx(host_idx), .eidx(eng_idx)
);

// File: tb/smb_blkbuf_tb.sv
module smb_blkbuf_tb;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0] h_sel = '0;
    logic h_wr = 0, h_rd = 0;
    logic [7:0] h_wdata = '0, h_rdata;
    logic e_start = 0, e_dir_rx = 0, e_rd = 0, e_wr = 0, e_cnt_vld = 0, e_end = 0, e_err = 0;
    logic [7:0] e_wdata = '0, e_cnt = '0, e_rdata, e_count;
    logic busy, proto_err, xfer_err, buf_mode;

    logic [1:0] n_sel = '0;
    logic n_wr = 0;
    logic [7:0] n_wdata = '0, n_rdata, n_erdata, n_count;
    logic n_busy, n_perr, n_xerr, n_mode;

    smb_blkbuf u_dut (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_rd(h_rd),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .e_start(e_start), .e_dir_rx(e_dir_rx),
        .e_rd(e_rd), .e_rdata(e_rdata), .e_wr(e_wr), .e_wdata(e_wdata),
        .e_cnt_vld(e_cnt_vld), .e_cnt(e_cnt), .e_end(e_end), .e_err(e_err),
        .e_count(e_count), .busy(busy), .proto_err(proto_err), .xfer_err(xfer_err),
        .buf_mode(buf_mode)
    );

    smb_blkbuf #(.HAS_BUF(1'b0)) u_dut_nobuf (
        .clk(clk), .rst_n(rst_n), .h_sel(n_sel), .h_wr(n_wr), .h_rd(1'b0),
        .h_wdata(n_wdata), .h_rdata(n_rdata), .e_start(1'b0), .e_dir_rx(1'b0),
        .e_rd(1'b0), .e_rdata(n_erdata), .e_wr(1'b0), .e_wdata(8'h00),
        .e_cnt_vld(1'b0), .e_cnt(8'h00), .e_end(1'b0), .e_err(1'b0),
        .e_count(n_count), .busy(n_busy), .proto_err(n_perr), .xfer_err(n_xerr),
        .buf_mode(n_mode)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_mem [DEPTH];
    int hi = 0;
    int ei = 0;

    function automatic int step_idx(int i);
        return (i < DEPTH - 1) ? i + 1 : DEPTH - 1;
    endfunction

    function automatic logic cnt_bad(int c);
        return (c < 1) || (c > DEPTH);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic hwrite(logic [1:0] sel, logic [7:0] d);
        h_sel = sel; h_wdata = d; h_wr = 1;
        tick();
        h_wr = 0;
        if (sel == 2'd2 && buf_mode) begin
            ref_mem[hi] = d;
            hi = step_idx(hi);
        end
    endtask

    task automatic hread(logic [1:0] sel, output logic [7:0] d);
        logic adv;
        adv = (sel == 2'd2) && buf_mode;
        h_sel = sel; h_rd = 1;
        #1 d = h_rdata;
        tick();
        h_rd = 0;
        if (sel == 2'd0) hi = 0;
        else if (adv) hi = step_idx(hi);
    endtask

    task automatic ctrl_read();
        logic [7:0] d;
        hread(2'd0, d);
    endtask

    task automatic eng_start(logic rx);
        e_start = 1; e_dir_rx = rx;
        tick();
        e_start = 0;
        if (buf_mode) ei = 0;
    endtask

    task automatic eng_put(logic [7:0] d);
        e_wr = 1; e_wdata = d;
        tick();
        e_wr = 0;
        ref_mem[ei] = d;
        ei = step_idx(ei);
    endtask

    task automatic eng_finish(logic err);
        e_end = 1; e_err = err;
        tick();
        e_end = 0; e_err = 0;
        tick();
    endtask

    task automatic host_readback(string req, int n);
        logic [7:0] d;
        logic [7:0] exp;
        ctrl_read();
        for (int i = 0; i < n; i++) begin
            exp = ref_mem[hi];
            hread(2'd2, d);
            chk(req, d, exp);
        end
    endtask

    task automatic rx_xfer(int n, int cnt, logic err);
        logic [7:0] d;
        eng_start(1'b1);
        chk("R12 busy in receive", {7'd0, busy}, 8'd1);
        for (int i = 0; i < n; i++) eng_put(8'($urandom));
        e_cnt_vld = 1; e_cnt = 8'(cnt);
        tick();
        e_cnt_vld = 0;
        eng_finish(err);
        chk("R12 busy cleared", {7'd0, busy}, 8'd0);
        chk("R9 proto_err", {7'd0, proto_err}, {7'd0, !err && cnt_bad(cnt)});
        chk("R10 xfer_err", {7'd0, xfer_err}, {7'd0, err});
        hread(2'd1, d);
        chk("R5 received count", d, 8'(cnt));
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] last;
        int n;
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        tick(); tick();
        rst_n = 1;
        tick();

        // reset state
        hread(2'd1, d); chk("R5 count reset", d, 8'h00);
        hread(2'd3, d); chk("R6 aux reset", d, 8'h00);
        chk("R12 idle after reset", {5'd0, busy, proto_err, xfer_err}, 8'h00);

        // mode off: block port writes ignored, reads zero, start ignored
        hwrite(2'd2, 8'hA5); hwrite(2'd2, 8'h5A);
        hread(2'd2, d); chk("R6 read zero with mode off", d, 8'h00);
        eng_start(1'b1);
        chk("R6 start ignored with mode off", {7'd0, busy}, 8'd0);
        hwrite(2'd3, 8'h02);
        hread(2'd3, d); chk("R6 aux bit readback", d, 8'h02);
        host_readback("R1 entries zero after reset", 4);

        // R11 variant without buffer support
        n_sel = 2'd3; n_wdata = 8'hFF; n_wr = 1;
        tick();
        n_wr = 0;
        #1 chk("R11 aux bit stuck at 0", n_rdata, 8'h00);

        // random host fills, checked by host and engine reads
        for (int t = 0; t < 6; t++) begin
            n = 1 + ($urandom % DEPTH);
            ctrl_read();
            hwrite(2'd1, 8'(n));
            for (int i = 0; i < n; i++) hwrite(2'd2, 8'($urandom));
            host_readback("R1 random fill readback", n);
            hread(2'd1, d); chk("R5 count readback", d, 8'(n));
            eng_start(1'b0);
            chk("R5 count on engine side", e_count, 8'(n));
            for (int i = 0; i < n; i++) begin
                e_rd = 1;
                #1 chk("R7 transmit order", e_rdata, ref_mem[ei]);
                tick();
                e_rd = 0;
                ei = step_idx(ei);
            end
            eng_finish(1'b0);
            chk("R12 transmit done", {5'd0, busy, proto_err, xfer_err}, 8'h00);
        end

        // R3: reads advance the index too
        ctrl_read();
        hwrite(2'd2, 8'h11);
        hread(2'd2, d); chk("R3 read at position 1", d, ref_mem[1]);
        hwrite(2'd2, 8'h33);
        host_readback("R3 interleaved", 3);

        // R4: overrun saturates at the last entry
        ctrl_read();
        for (int i = 0; i < DEPTH + 1; i++) hwrite(2'd2, 8'($urandom));
        last = ref_mem[DEPTH - 1];
        host_readback("R4 saturating fill", DEPTH);
        hread(2'd2, d); chk("R4 read past end", d, last);
        hread(2'd2, d); chk("R4 read past end again", d, last);

        // receive transfers
        rx_xfer(1, 1, 1'b0);
        host_readback("R8 receive count 1", 1);
        rx_xfer(DEPTH, DEPTH, 1'b0);
        host_readback("R8 receive full", DEPTH);
        rx_xfer(0, 0, 1'b0);
        eng_start(1'b1);
        chk("R9 start clears proto_err", {7'd0, proto_err}, 8'd0);
        eng_finish(1'b0);
        rx_xfer(3, DEPTH + 1, 1'b0);

        // R10: error end keeps buffer contents
        rx_xfer(2, 0, 1'b1);
        host_readback("R10 contents after error", DEPTH);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule